// File: doc/BRIEF.md
# Serializer with On-the-Fly Parity Insertion

The block takes an 8-bit parallel word and sends it out one bit per clock, lowest bit first. The low seven bits carry a character code; the top bit arrives as a zero placeholder. While the seven character bits leave the block, a one-bit parity machine accumulates their XOR. In the eighth slot the block sends that accumulated parity bit instead of the placeholder, so the finished stream always has even parity over all eight bits.

Internally the work is split in two. A datapath holds the load/shift register and a bit-position counter. A control unit holds the sequencing state machine and the single parity flip-flop. The state machine has four states. ST_IDLE waits for a load. ST_DATA shifts the seven character bits. ST_PARITY sends the parity slot. ST_DONE is the single cycle after the eighth bit. Its transitions are: idle_to_data on a load, data_loop while the counter is below the last data position, data_to_parity on the last data bit, parity_to_done always, done_to_data on a load in the done cycle, and done_to_idle otherwise.

Top module: `par_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o` and `ser_o` are all 0.
- R2: A load strobe sampled high while `busy_o` is 0 captures `word_i`. In the next cycle `busy_o` is 1 and `ser_o` shows bit 0 of the captured word.
- R3: The seven character bits appear on `ser_o` lowest first, one per cycle: bit k is in the (k+1)-th busy cycle, for k = 0 to 6.
- R4: The eighth busy cycle carries the even parity bit, which is the XOR of captured bits 0 to 6. The captured bit 7 never reaches `ser_o`.
- R5: `busy_o` stays high for exactly 8 consecutive cycles per accepted word.
- R6: `done_o` is high for exactly one cycle, the one right after the eighth bit, and `busy_o` is 0 in that cycle.
- R7: A load strobe while `busy_o` is 1 is ignored. The word in flight and its parity are not disturbed.
- R8: A load in the `done_o` cycle is accepted, so words can follow each other with a single-cycle gap.
- R9: Whenever `busy_o` is 0, `ser_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe for `word_i` |
| word_i | input | 8 | Parallel word; bits 0-6 are data, bit 7 is a placeholder |
| ser_o | output | 1 | Serial data, valid while `busy_o` is 1 |
| busy_o | output | 1 | High while the eight bits of a word are being sent |
| done_o | output | 1 | One-cycle pulse after the eighth bit |

## Verification
All 128 character codes are sent with idle gaps between them. Codes with an odd and an even number of ones separate a working parity slot from one that is stuck, inverted, or leaks the placeholder. Half of these codes are also sent with bit 7 set, which shows whether the placeholder is ever forwarded. Some words receive stray load strobes during transmission, which shows whether an in-flight word can be corrupted or restarted. A final run holds the load strobe high continuously, so that loads in the done cycle are exercised and a word cannot be skipped or repeated.

// File: rtl/par_ser_pkg.sv
package par_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_PARITY,
        ST_DONE
    } ser_state_t;

endpackage

// File: rtl/par_ser_datapath.sv
module par_ser_datapath #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word_i,
    output logic              lsb_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [WORD_W-1:0] sreg_q;
    logic [WORD_W-1:0] sreg_d;
    logic [CNT_W-1:0]  cnt_q;

    // each stage takes the parallel bit on load or its upper neighbour on shift
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_stage
        logic upper;
        if (gi == WORD_W - 1) begin : g_top
            assign upper = 1'b0;
        end else begin : g_mid
            assign upper = sreg_q[gi+1];
        end
        always_comb begin
            if (load_en) begin
                sreg_d[gi] = word_i[gi];
            end else if (shift_en) begin
                sreg_d[gi] = upper;
            end else begin
                sreg_d[gi] = sreg_q[gi];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else begin
            sreg_q <= sreg_d;
            if (load_en) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lsb_o = sreg_q[0];
    assign cnt_o = cnt_q;

endmodule

// File: rtl/par_ser_parity.sv
module par_ser_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_i,
    output logic par_o
);

    logic par_q;

    // single state bit: next = current serial bit XOR present state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else if (clr) begin
            par_q <= 1'b0;
        end else if (en) begin
            par_q <= par_q ^ bit_i;
        end
    end

    assign par_o = par_q;

endmodule

// File: rtl/par_ser_ctrl.sv
module par_ser_ctrl
    import par_ser_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W),
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WORD_W - 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             load_en,
    output logic             shift_en,
    output logic             busy_o,
    output logic             done_o
);

    ser_state_t state_q;
    ser_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) state_d = ST_DATA;        // idle_to_data
            end
            ST_DATA: begin
                if (cnt_i == LAST_DATA) state_d = ST_PARITY; // data_to_parity
            end
            ST_PARITY: begin
                state_d = ST_DONE;                     // parity_to_done
            end
            ST_DONE: begin
                if (load_i) state_d = ST_DATA;         // done_to_data
                else        state_d = ST_IDLE;         // done_to_idle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_en = load_i;
            ST_DATA: begin
                shift_en = 1'b1;
                busy_o   = 1'b1;
            end
            ST_PARITY: busy_o = 1'b1;
            ST_DONE: begin
                done_o  = 1'b1;
                load_en = load_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/par_serializer.sv
module par_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] PAR_SLOT = CNT_W'(WORD_W - 1);

    logic             load_en;
    logic             shift_en;
    logic             lsb;
    logic             par;
    logic [CNT_W-1:0] cnt;

    par_ser_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .word_i   (word_i),
        .lsb_o    (lsb),
        .cnt_o    (cnt)
    );

    par_ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .cnt_i    (cnt),
        .load_en  (load_en),
        .shift_en (shift_en),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    par_ser_parity u_par (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_en),
        .en    (shift_en),
        .bit_i (lsb),
        .par_o (par)
    );

    // counter picks the parity flop for the last slot, else the shifter output
    always_comb begin
        if (!busy_o) begin
            ser_o = 1'b0;
        end else if (cnt == PAR_SLOT) begin
            ser_o = par;
        end else begin
            ser_o = lsb;
        end
    end

endmodule

// File: rtl/par_serializer_chk.sv
module par_serializer_chk #(
    parameter int WORD_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic ser_o,
    input logic busy_o,
    input logic done_o
);

    localparam int RUN_W = $clog2(WORD_W) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2
    load_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !busy_o |=> busy_o);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run_q < RUN_W'(WORD_W));

    // R5
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(run_q) == RUN_W'(WORD_W - 1));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ser_o);

endmodule

bind par_serializer par_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .ser_o  (ser_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/test_par_serializer.sv
module test_par_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] word_i = '0;
    logic       ser_o;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    bit exp_q[$];
    bit exp_done = 1'b0;

    par_serializer i_par_serializer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .word_i (word_i),
        .ser_o  (ser_o),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: a queue of the bits still to be sent
    always @(posedge clk) begin
        bit busy_now;
        bit last_now;
        bit p;
        if (!rst_n) begin
            exp_q.delete();
            exp_done = 1'b0;
        end else begin
            busy_now = exp_q.size() != 0;
            last_now = exp_q.size() == 1;
            if (busy_now) void'(exp_q.pop_front());
            if (load_i && !busy_now) begin
                p = 1'b0;
                for (int i = 0; i < 7; i++) begin
                    exp_q.push_back(word_i[i]);
                    p ^= word_i[i];
                end
                exp_q.push_back(p);
            end
            exp_done = last_now;
        end
    end

    task automatic check_bit(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        bit eb;
        bit es;
        cycles++;
        if (rst_n && !finished) begin
            eb = exp_q.size() != 0;
            es = eb ? exp_q[0] : 1'b0;
            check_bit("R5 busy", busy_o, eb);
            if (!eb)                  check_bit("R9 idle line", ser_o, es);
            else if (exp_q.size()==1) check_bit("R4 parity slot", ser_o, es);
            else                      check_bit("R3 data bit", ser_o, es);
            check_bit("R6 done", done_o, exp_done);
        end
        if (cycles > WATCHDOG && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R2 R7: send one word, optionally strobe load mid-flight with another word
    task automatic send(logic [7:0] w, bit poke);
        @(negedge clk);
        load_i = 1'b1;
        word_i = w;
        @(negedge clk);
        load_i = 1'b0;
        word_i = ~w;
        if (poke) begin
            repeat (3) @(negedge clk);
            load_i = 1'b1;
            @(negedge clk);
            load_i = 1'b0;
        end
        repeat (poke ? 6 : 10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check_bit("R1 busy in reset", busy_o, 1'b0);
        check_bit("R1 done in reset", done_o, 1'b0);
        check_bit("R1 ser in reset", ser_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 busy after reset", busy_o, 1'b0);

        // R3 R4: every character code, placeholder set on half of them
        for (int c = 0; c < 128; c++) begin
            send({c[0], c[6:0]}, c % 4 == 1);
        end

        // R8: strobe held high, loads land in the done cycle
        @(negedge clk);
        load_i = 1'b1;
        for (int k = 0; k < 60; k++) begin
            word_i = 8'(k * 37 + 5);
            @(negedge clk);
        end
        load_i = 1'b0;
        repeat (12) @(negedge clk);
        report();
    end

endmodule